// File: doc/BRIEF.md
# Supervisory Reset Generator With Release Delay

This block produces the system reset for a chip from three fault sources: a supply-good flag, a sense-input-good flag and an active-low manual reset pin. The two threshold flags come from analog comparators outside the block and arrive already synchronized to the block's free-running timebase clock. While any fault is present the reset is held. Once every fault has cleared, a counter runs for a fixed number of timebase cycles before the reset lets go. Any fault that appears during that count aborts it, and the full count starts again after the fault clears.

Short dips on the sense flag are filtered out. A sense fault counts only after the flag has been low for a minimum run of consecutive cycles. Supply and manual faults act on the next clock edge. The reset leaves the block as a complementary pair of registered outputs. A status bit carries the same asserted state to the chip-enable gating logic.

Top module: `sup_rst_gen`

## Requirements
- R1: While `rst` is high, and after `rst` falls with all inputs good, `sys_rst` stays 1 until the DELAY_CYC-th rising edge after `rst` falls. That edge makes it 0.
- R2: A low `supply_ok` sampled at a rising edge makes `sys_rst` 1 from that edge on.
- R3: Once all faults clear, `sys_rst` falls at exactly the DELAY_CYC-th consecutive fault-free rising edge. For a supply or manual fault whose last faulty edge is n, the release edge is n+DELAY_CYC.
- R4: `sys_rst_n` is always the inverse of `sys_rst`.
- R5: A low `mr_n` sampled at a rising edge forces `sys_rst` to 1 from that edge on. Release follows the rule in R3.
- R6: `sense_ok` low for at least GLITCH_CYC consecutive edges, numbered 1 to L, asserts `sys_rst` at edge GLITCH_CYC+1. The fault clears at edge L+1, and `sys_rst` falls at edge L+1+DELAY_CYC.
- R7: `sense_ok` low for fewer than GLITCH_CYC consecutive edges leaves `sys_rst` at 0 throughout.
- R8: A fault occurring while the release count runs restarts it. Release then comes DELAY_CYC edges after the new fault's last edge, not at the earlier release point.
- R9: `rst_status` equals `sys_rst` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running timebase clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| supply_ok | input | 1 | 1 when the monitored supply is above threshold (synchronized) |
| sense_ok | input | 1 | 1 when the sense input is above threshold (synchronized) |
| mr_n | input | 1 | Manual reset, active low (synchronized) |
| sys_rst | output | 1 | Active-high system reset |
| sys_rst_n | output | 1 | Active-low system reset |
| rst_status | output | 1 | Reset-asserted status for chip-enable gating |

## Verification
The assertions assume that all three fault inputs are already synchronous to `clk` and change only between edges. They also assume the power-on reset is applied from time zero. The stimulus follows both rules: every input changes at the falling clock edge, and `rst` is held high from the start. Pulse lengths are swept around the glitch limit and across the delay window. Release edges are predicted from the pulse length by arithmetic.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;
  // Width needed to hold counts 0..n
  function automatic int cnt_w(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  typedef struct packed {
    logic supply_bad;
    logic sense_bad;
    logic manual;
  } fault_t;
endpackage

// File: rtl/srg_sense_filter.sv
module srg_sense_filter #(
  parameter int GLITCH_CYC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic sense_ok,
  output logic fault
);
  import sup_rst_pkg::*;
  localparam int CW = cnt_w(GLITCH_CYC);
  localparam logic [CW-1:0] LAST = CW'(GLITCH_CYC - 1);

  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || sense_ok) begin
      low_cnt <= '0;
      fault   <= 1'b0;
    end else if (low_cnt == LAST) begin
      fault   <= 1'b1;
    end else begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  // R7: a good sample always clears the filtered fault
  p_good_clears_r7: assert property (@(posedge clk) disable iff (rst)
    sense_ok |=> !fault);
  // R6: a fault only appears after a low sample
  p_fault_from_low_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> $past(!sense_ok));
endmodule

// File: rtl/srg_release_timer.sv
module srg_release_timer #(
  parameter int DELAY_CYC = 100000
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  output logic busy,
  output logic busy_n
);
  import sup_rst_pkg::*;
  localparam int CW = cnt_w(DELAY_CYC);
  localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      busy   <= 1'b1;
      busy_n <= 1'b0;
      cnt    <= '0;
    end else if (busy) begin
      if (cnt == LAST) begin
        busy   <= 1'b0;
        busy_n <= 1'b1;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2: any fault asserts reset at the next edge
  p_hold_sets_r2: assert property (@(posedge clk) disable iff (rst)
    hold |=> busy);
  // R4: the two output registers never agree
  p_complement_r4: assert property (@(posedge clk) disable iff (rst)
    busy != busy_n);
  // R3: release never happens on a faulty edge
  p_release_clean_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(!hold));
  // R8: once released, reset stays off while faults are absent
  p_stay_off_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !hold) |=> !busy);
endmodule

// File: rtl/sup_rst_gen.sv
module sup_rst_gen #(
  parameter int DELAY_CYC  = 100000,
  parameter int GLITCH_CYC = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic sense_ok,
  input  logic mr_n,
  output logic sys_rst,
  output logic sys_rst_n,
  output logic rst_status
);
  import sup_rst_pkg::*;

  fault_t faults;
  logic   sense_fault;
  logic   hold;

  srg_sense_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
    .clk(clk), .rst(rst), .sense_ok(sense_ok), .fault(sense_fault)
  );

  always_comb begin
    faults.supply_bad = !supply_ok;
    faults.sense_bad  = sense_fault;
    faults.manual     = !mr_n;
    hold              = |faults;
  end

  srg_release_timer #(.DELAY_CYC(DELAY_CYC)) u_tmr (
    .clk(clk), .rst(rst), .hold(hold), .busy(sys_rst), .busy_n(sys_rst_n)
  );

  assign rst_status = sys_rst;

  // R5: manual reset forces reset at the next edge
  p_manual_forces_r5: assert property (@(posedge clk) disable iff (rst)
    !mr_n |=> sys_rst);
  // R1: reset is asserted right after power-on reset
  p_por_asserts_r1: assert property (@(posedge clk)
    rst |=> sys_rst);
endmodule

// File: tb/sup_rst_gen_tb.sv
module sup_rst_gen_tb;
  localparam int D = 8;
  localparam int G = 3;

  logic clk = 0, rst = 1, supply_ok = 1, sense_ok = 1, mr_n = 1;
  logic sys_rst, sys_rst_n, rst_status;
  int total = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  sup_rst_gen #(.DELAY_CYC(D), .GLITCH_CYC(G)) u_dut (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .sense_ok(sense_ok),
    .mr_n(mr_n), .sys_rst(sys_rst), .sys_rst_n(sys_rst_n), .rst_status(rst_status)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R4/R9 checked at every sample
  task automatic pair_chk();
    if (sys_rst_n == sys_rst) chk("R4", int'(sys_rst_n), int'(!sys_rst));
    if (rst_status != sys_rst) chk("R9", int'(rst_status), int'(sys_rst));
  endtask

  task automatic set_in(input int kind, input logic v);
    case (kind)
      0: supply_ok = v;
      1: mr_n = v;
      default: sense_ok = v;
    endcase
  endtask

  // drive input low for len edges, record first asserted and release edge
  task automatic pulse(input int kind, input int len, input int exp_on,
                       input int exp_rel, input string req);
    int on_k = 0, rel_k = 0;
    set_in(kind, 1'b0);
    for (int k = 1; k <= len + D + 6; k++) begin
      @(posedge clk); @(negedge clk);
      pair_chk();
      if (on_k == 0 && sys_rst) on_k = k;
      if (on_k != 0 && rel_k == 0 && !sys_rst) rel_k = k;
      if (k == len) set_in(kind, 1'b1);
    end
    chk(req, on_k, exp_on);
    chk(req, rel_k, exp_rel);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", int'(sys_rst), 1);
    chk("R4", int'(sys_rst_n), 0);
    chk("R9", int'(rst_status), 1);
    rst = 0;
    // R1: release exactly at edge D after reset falls
    for (int k = 1; k <= D + 2; k++) begin
      @(posedge clk); @(negedge clk);
      pair_chk();
      if (k == D - 1 || k == D || k == D + 2)
        chk("R1", int'(sys_rst), (k >= D) ? 0 : 1);
    end
    // R2/R3: supply dips of several lengths
    for (int l = 1; l <= 4; l++) pulse(0, l, 1, l + D, "R2_R3");
    // R5: manual reset pulses
    for (int l = 1; l <= 3; l++) pulse(1, l, 1, l + D, "R5");
    // R6/R7: sense sweep around the glitch limit
    for (int l = 1; l <= G + 4; l++) begin
      if (l < G) pulse(2, l, 0, 0, "R7");
      else       pulse(2, l, G + 1, l + 1 + D, "R6");
    end
    // R8: manual fault during release count restarts it
    begin
      int rel_k = 0;
      supply_ok = 0;
      for (int k = 1; k <= 5 + D + 4; k++) begin
        @(posedge clk); @(negedge clk);
        pair_chk();
        if (k == 2 + D) chk("R8", int'(sys_rst), 1);
        if (rel_k == 0 && !sys_rst) rel_k = k;
        if (k == 2) supply_ok = 1;
        if (k == 4) mr_n = 0;
        if (k == 5) mr_n = 1;
      end
      chk("R8", rel_k, 5 + D);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule